// File: doc/BRIEF.md
# Timing Link Word Framer

This block builds the transmit word of a timing distribution link. On every link clock (one slot, about 8.4 ns at the intended rate) it produces a 16-bit word made of an 8-bit event code and an 8-bit data byte. The event code comes from an upstream event queue. When nothing is queued, the code is the null value 0x00.

The data byte is shared between two producers. The first is a protection-status byte. A changed status value is sent as soon as it appears. While the status holds still, idle data slots repeat the last status byte that was sent. The second producer is a bulk buffer transfer of 1 to 2048 bytes that carries the per-pulse timing pattern; bytes 16 to 23 of that pattern are an 8-byte timestamp. A transfer is framed in the data slot by a start marker, then the payload bytes with their addresses, then an end marker, then a 16-bit checksum.

A 2-bit selector goes with each word so that the receiver knows what the data byte holds. The event input is a valid/ready stream, and its ready output is always high because every slot can carry a code. The buffer payload input is a valid/ready stream: a byte is consumed only in a cycle where `buf_valid` and `buf_ready` are both high. When the source holds `buf_valid` low, the transfer stalls and that slot repeats the status byte. A stall does not change the order or addresses of the payload bytes.

Top module: `evl_slot_mux`

## Requirements
- R1: While `rst_n` is low, and after reset before any stimulus, `lnk_code`, `lnk_data`, `lnk_addr` and `lnk_ts` are 0, `lnk_dsel` is 0 and `busy` is 0.
- R2: `ev_ready` is always 1. One clock after a cycle with `ev_valid` high, `lnk_code` equals the `ev_code` of that cycle. One clock after a cycle with `ev_valid` low, `lnk_code` is 0x00.
- R3: When `st_byte` differs from the last status byte sent, the next word carries `st_byte` with `lnk_dsel` = 2'b01. That value then becomes the last status byte sent.
- R4: When the status is unchanged and no transfer byte uses the slot, the next word repeats the last status byte sent, with `lnk_dsel` = 2'b00.
- R5: A status change takes the data slot even during a transfer. The transfer does not advance in that slot, and `buf_ready` is low in that cycle.
- R6: A transfer sends, in this order and with `lnk_dsel` = 2'b11: the start marker 0xF0 before the payload; after the payload, the end marker 0x0F, the checksum high byte, and the checksum low byte.
- R7: Payload bytes go out with `lnk_dsel` = 2'b10, in the order they were accepted, with `lnk_addr` counting up from 0. `buf_ready` is high only in a payload slot that the status does not take. If `buf_valid` is low in such a slot, that word is a status resend.
- R8: The checksum is the sum of all payload bytes, modulo 2^16.
- R9: `busy` rises one clock after `xfer_start` is seen while idle. It falls on the same clock that the checksum low byte is output. An `xfer_start` seen while `busy` is high is ignored.
- R10: `lnk_ts` is 1 exactly on payload words whose address is between 16 and 23, inclusive.
- R11: `xfer_len` gives the payload byte count minus one, so 0 means 1 byte and 2047 means 2048 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event code offered |
| ev_ready | output | 1 | Event code accepted (always 1) |
| ev_code | input | 8 | Event code to send |
| st_byte | input | 8 | Current protection-status byte |
| xfer_start | input | 1 | Request a buffer transfer |
| xfer_len | input | 11 | Payload byte count minus one |
| buf_valid | input | 1 | Payload byte offered |
| buf_ready | output | 1 | Payload byte consumed this cycle |
| buf_data | input | 8 | Payload byte |
| busy | output | 1 | Transfer in progress |
| lnk_code | output | 8 | Event code of the link word |
| lnk_data | output | 8 | Data byte of the link word |
| lnk_dsel | output | 2 | Data meaning: 00 status resend, 01 new status, 10 payload, 11 framing |
| lnk_addr | output | 11 | Payload address (0 when not payload) |
| lnk_ts | output | 1 | Payload byte lies in the timestamp range |

## Verification
The hardest case to reach is a collision inside a single transfer. In that case a status change takes a slot, a source stall empties another slot, and a request arrives while the block is busy. The bench must then confirm that the payload order, the addresses and the checksum all survive. Each directed task picks the exact cycles, counted from the start of the transfer, at which it flips `st_byte`, drops `buf_valid` or raises `xfer_start` again. Each cycle is checked against a word the bench computes itself. A 24-byte transfer covers the timestamp address window.

// File: rtl/evl_pkg.sv
package evl_pkg;
  typedef enum logic [1:0] {
    DS_ST_RESEND = 2'b00,
    DS_ST_NEW    = 2'b01,
    DS_PAYLOAD   = 2'b10,
    DS_FRAME     = 2'b11
  } dsel_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_PAY, PH_END, PH_CKH, PH_CKL
  } phase_e;
endpackage

// File: rtl/evl_status_track.sv
module evl_status_track #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] st_in,
  output logic         chg,
  output logic [W-1:0] last
);
  // Change wins the slot unconditionally, so the new value is sent at once.
  assign chg = (st_in != last);

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= '0;
    else if (chg) last <= st_in;
  end
endmodule

// File: rtl/evl_buf_framer.sv
module evl_buf_framer
  import evl_pkg::*;
#(
  parameter int          DEPTH      = 2048,
  parameter int          W          = 8,
  parameter logic [W-1:0] START_MARK = 8'hF0,
  parameter logic [W-1:0] END_MARK   = 8'h0F,
  localparam int         AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_start,
  input  logic [AW-1:0] xfer_len,
  input  logic          grant,
  input  logic          buf_valid,
  output logic          buf_ready,
  input  logic [W-1:0]  buf_data,
  output logic          busy,
  output logic          req,
  output logic          frame,
  output logic [W-1:0]  out_byte,
  output logic [AW-1:0] out_addr
);
  phase_e        phase;
  logic [AW-1:0] idx, last_idx;
  logic [15:0]   sum;
  logic          adv;

  assign busy      = (phase != PH_IDLE);
  assign req       = busy && (phase != PH_PAY || buf_valid);
  assign adv       = grant && req;
  assign buf_ready = (phase == PH_PAY) && grant;
  assign frame     = (phase != PH_PAY);
  assign out_addr  = idx;

  always_comb begin
    case (phase)
      PH_START: out_byte = START_MARK;
      PH_PAY:   out_byte = buf_data;
      PH_END:   out_byte = END_MARK;
      PH_CKH:   out_byte = sum[15:8];
      PH_CKL:   out_byte = sum[7:0];
      default:  out_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      last_idx <= '0;
      sum      <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (xfer_start) begin
          phase    <= PH_START;
          last_idx <= xfer_len;
          idx      <= '0;
          sum      <= '0;
        end
        PH_START: if (adv) phase <= PH_PAY;
        PH_PAY: if (adv) begin
          sum <= sum + 16'(buf_data);
          if (idx == last_idx) phase <= PH_END;
          else                 idx   <= idx + 1'b1;
        end
        PH_END:  if (adv) phase <= PH_CKH;
        PH_CKH:  if (adv) phase <= PH_CKL;
        PH_CKL:  if (adv) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evl_slot_mux.sv
module evl_slot_mux
  import evl_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int TS_FIRST = 16,
  parameter int TS_LEN   = 8,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [7:0]    ev_code,
  input  logic [7:0]    st_byte,
  input  logic          xfer_start,
  input  logic [AW-1:0] xfer_len,
  input  logic          buf_valid,
  output logic          buf_ready,
  input  logic [7:0]    buf_data,
  output logic          busy,
  output logic [7:0]    lnk_code,
  output logic [7:0]    lnk_data,
  output logic [1:0]    lnk_dsel,
  output logic [AW-1:0] lnk_addr,
  output logic          lnk_ts
);
  localparam int TS_END = TS_FIRST + TS_LEN;

  logic          st_chg;
  logic [7:0]    st_last;
  logic          fr_req, fr_frame;
  logic [7:0]    fr_byte;
  logic [AW-1:0] fr_addr;
  logic          in_ts;

  evl_status_track #(.W(8)) u_status (
    .clk(clk), .rst_n(rst_n), .st_in(st_byte), .chg(st_chg), .last(st_last)
  );

  evl_buf_framer #(.DEPTH(DEPTH), .W(8)) u_framer (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .grant(!st_chg), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .buf_data(buf_data), .busy(busy), .req(fr_req), .frame(fr_frame),
    .out_byte(fr_byte), .out_addr(fr_addr)
  );

  assign ev_ready = 1'b1;
  assign in_ts    = (int'(fr_addr) >= TS_FIRST) && (int'(fr_addr) < TS_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lnk_code <= '0;
      lnk_data <= '0;
      lnk_dsel <= DS_ST_RESEND;
      lnk_addr <= '0;
      lnk_ts   <= 1'b0;
    end else begin
      lnk_code <= ev_valid ? ev_code : 8'h00;
      lnk_addr <= '0;
      lnk_ts   <= 1'b0;
      if (st_chg) begin
        lnk_data <= st_byte;
        lnk_dsel <= DS_ST_NEW;
      end else if (fr_req) begin
        lnk_data <= fr_byte;
        lnk_dsel <= fr_frame ? DS_FRAME : DS_PAYLOAD;
        if (!fr_frame) begin
          lnk_addr <= fr_addr;
          lnk_ts   <= in_ts;
        end
      end else begin
        lnk_data <= st_last;
        lnk_dsel <= DS_ST_RESEND;
      end
    end
  end
endmodule

// File: rtl/evl_slot_mux_chk.sv
module evl_slot_mux_chk #(
  parameter int AW       = 11,
  parameter int TS_FIRST = 16,
  parameter int TS_LEN   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [7:0]    ev_code,
  input logic          buf_valid,
  input logic          buf_ready,
  input logic          busy,
  input logic          xfer_start,
  input logic [7:0]    lnk_code,
  input logic [1:0]    lnk_dsel,
  input logic [AW-1:0] lnk_addr,
  input logic          lnk_ts
);
  AST_NULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> lnk_code == 8'h00); // R2
  AST_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> lnk_code == $past(ev_code)); // R2
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready); // R2
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> busy); // R7
  AST_TAKE_IS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ready && buf_valid) |=> lnk_dsel == 2'b10); // R7
  AST_TS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ts |-> (lnk_dsel == 2'b10 && int'(lnk_addr) >= TS_FIRST
                && int'(lnk_addr) < TS_FIRST + TS_LEN)); // R10
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_start) |=> busy); // R9
endmodule

bind evl_slot_mux evl_slot_mux_chk #(.AW(AW), .TS_FIRST(TS_FIRST), .TS_LEN(TS_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_code(ev_code), .buf_valid(buf_valid), .buf_ready(buf_ready),
  .busy(busy), .xfer_start(xfer_start), .lnk_code(lnk_code),
  .lnk_dsel(lnk_dsel), .lnk_addr(lnk_addr), .lnk_ts(lnk_ts)
);

// File: tb/evl_slot_mux_test.sv
`timescale 1ns/100ps
module evl_slot_mux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0, ev_ready;
  logic [7:0]  ev_code = '0;
  logic [7:0]  st_byte = '0;
  logic        xfer_start = 1'b0;
  logic [10:0] xfer_len = '0;
  logic        buf_valid = 1'b0, buf_ready;
  logic [7:0]  buf_data = '0;
  logic        busy, lnk_ts;
  logic [7:0]  lnk_code, lnk_data;
  logic [1:0]  lnk_dsel;
  logic [10:0] lnk_addr;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_last = 8'h00;

  always #2.5 clk = ~clk;

  evl_slot_mux uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .st_byte(st_byte), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .buf_data(buf_data), .busy(busy), .lnk_code(lnk_code),
    .lnk_data(lnk_data), .lnk_dsel(lnk_dsel), .lnk_addr(lnk_addr),
    .lnk_ts(lnk_ts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    step(); step();
    chk("R1 code", 32'(lnk_code), 0);
    chk("R1 data", 32'(lnk_data), 0);
    chk("R1 dsel", 32'(lnk_dsel), 0);
    chk("R1 busy", 32'(busy), 0);
    rst_n = 1'b1;
    step();
    chk("R1 ts after release", 32'(lnk_ts), 0);
    chk("R1 addr after release", 32'(lnk_addr), 0);
    chk("R1 idle resend", 32'(lnk_dsel), 0);
  endtask

  task automatic t_event;
    ev_valid = 1'b1; ev_code = 8'h7E;
    chk("R2 ev_ready", 32'(ev_ready), 1);
    step();
    chk("R2 code passed", 32'(lnk_code), 32'h7E);
    ev_code = 8'h01;
    step();
    chk("R2 code passed 2", 32'(lnk_code), 32'h01);
    ev_valid = 1'b0; ev_code = 8'hAA;
    step();
    chk("R2 null code", 32'(lnk_code), 0);
  endtask

  task automatic t_status;
    st_byte = 8'h5A;
    step();
    chk("R3 new dsel", 32'(lnk_dsel), 1);
    chk("R3 new data", 32'(lnk_data), 32'h5A);
    exp_last = 8'h5A;
    step();
    chk("R4 resend dsel", 32'(lnk_dsel), 0);
    chk("R4 resend data", 32'(lnk_data), 32'h5A);
  endtask

  // Drive one transfer of n bytes; status flips at cycle st_at, source stalls
  // at cycle stall_at, a second request is raised at cycle rs_at (-1 = none).
  task automatic t_xfer(input int n, input int st_at, input int stall_at, input int rs_at);
    int pos = 0;
    int cyc = 0;
    logic [15:0] sum = 16'h0;
    logic [1:0] e_ds;
    logic [7:0] e_dat;
    int e_addr;
    logic e_ts;
    xfer_start = 1'b1; xfer_len = 11'(n - 1);
    step();
    xfer_start = 1'b0;
    chk("R9 busy rises", 32'(busy), 1);
    for (int i = 0; i < n; i++) sum = sum + 16'(pat(i));
    while (pos < n + 4 && cyc < 4 * n + 40) begin
      if (cyc == st_at) st_byte = st_byte + 8'h11;
      xfer_start = (cyc == rs_at);
      buf_valid = (pos >= 1 && pos <= n) && (cyc != stall_at);
      buf_data  = (pos >= 1 && pos <= n) ? pat(pos - 1) : 8'h00;
      #0.5;
      e_addr = 0; e_ts = 1'b0;
      if (st_byte != exp_last) begin
        e_ds = 2'b01; e_dat = st_byte; exp_last = st_byte;
        chk("R5 ready low on status", 32'(buf_ready), 0);
      end else if (pos >= 1 && pos <= n && !buf_valid) begin
        e_ds = 2'b00; e_dat = exp_last;
      end else begin
        if (pos == 0)           begin e_ds = 2'b11; e_dat = 8'hF0; end
        else if (pos <= n)      begin e_ds = 2'b10; e_dat = pat(pos - 1);
                                      e_addr = pos - 1; e_ts = (e_addr >= 16 && e_addr <= 23); end
        else if (pos == n + 1)  begin e_ds = 2'b11; e_dat = 8'h0F; end
        else if (pos == n + 2)  begin e_ds = 2'b11; e_dat = sum[15:8]; end
        else                    begin e_ds = 2'b11; e_dat = sum[7:0]; end
        if (pos >= 1 && pos <= n) chk("R7 ready in payload slot", 32'(buf_ready), 1);
        pos++;
      end
      step();
      cyc++;
      chk("R6 R7 dsel", 32'(lnk_dsel), 32'(e_ds));
      chk(e_ds == 2'b11 && pos > n + 2 ? "R8 checksum" : "R6 R7 data", 32'(lnk_data), 32'(e_dat));
      chk("R7 addr", 32'(lnk_addr), 32'(e_addr));
      chk("R10 ts flag", 32'(lnk_ts), 32'(e_ts));
      if (pos < n + 4) chk("R9 busy held", 32'(busy), 1);
    end
    xfer_start = 1'b0; buf_valid = 1'b0;
    chk("R9 busy falls with last word", 32'(busy), 0);
    step();
    chk("R9 request while busy ignored", 32'(lnk_dsel), 0);
    chk("R9 still idle", 32'(busy), 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_event();
    t_status();
    t_xfer(4, -1, -1, -1);      // R6 R8 plain transfer
    t_xfer(1, -1, -1, -1);      // R11 single byte
    t_xfer(6, 3, 5, 2);         // R5 R7 R9 collisions
    t_xfer(24, 18, 10, 20);     // R10 timestamp window
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule